// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a 12-bit successive-approximation analog-to-digital converter. It chooses the start source, either a software start request or a timer trigger pulse. It runs a timed sample phase. It then steps a search register through one binary trial per bit, from the most significant bit down. At the end it copies the finished code into a separate result register and raises a one-cycle end-of-conversion interrupt.

The analog parts sit outside the block. The resistor-string DAC takes the tap code, and a comparator reports whether the held input is at or above that tap. The block drives a sample/hold control pair, so the held voltage stays frozen from the end of sampling until the conversion finishes.

A conversion is only accepted while the converter enable input is high. Clearing the enable during a conversion aborts the conversion. The start flag that the software sets clears itself when the conversion ends.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `result` is 0, and `busy`, `eoc_irq`, `sh_sample`, `sh_hold`, `start_flag` and `tap_code` are all 0.
- R2: When `trig_timer_mode` is 0, a `sw_start_wr` pulse with `conv_en` high starts a conversion: `busy`, `start_flag` and `sh_sample` go high on the next clock. A `timer_trig` pulse in this mode has no effect.
- R3: When `trig_timer_mode` is 1, a `timer_trig` pulse with `conv_en` high starts a conversion. A `sw_start_wr` pulse in this mode has no effect, and `start_flag` stays 0.
- R4: While `conv_en` is 0, start requests from either source are ignored and `busy` stays 0.
- R5: The sample phase (`sh_sample` = 1, `sh_hold` = 0) lasts N clock cycles. N is the value of `smp_cfg` captured at acceptance, with a floor of 2 cycles.
- R6: On the cycle after sampling ends, `sh_hold` goes to 1 and `tap_code` is 12'h800. `sh_hold` stays 1 through all trials. Outside the trials `tap_code` is 0.
- R7: Each bit trial takes two cycles. The tap is held for one settling cycle, and `cmp_ge` is sampled at the end of the second cycle. The bit under test stays 1 if `cmp_ge` is 1 and is cleared otherwise, and the next lower bit is then set. As a result, the second tap is 12'hC00 or 12'h400.
- R8: Acceptance happens at clock edge A. At edge A+N+24, `result` takes the final code, `eoc_irq` is 1 for exactly one cycle, and `busy` returns to 0. `result` does not change at any other time.
- R9: Start requests that arrive while `busy` is 1 are ignored, and the running conversion keeps its timing.
- R10: `start_flag` clears at the edge where the conversion completes.
- R11: If `conv_en` is 0 during a conversion, the next edge returns the block to idle. `result` keeps its value and no `eoc_irq` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Converter/comparator enable; must be high to start and to continue |
| trig_timer_mode | input | 1 | 0 = software start source, 1 = timer trigger source |
| sw_start_wr | input | 1 | One-cycle pulse: software writes the start flag to 1 |
| timer_trig | input | 1 | One-cycle timer trigger pulse |
| smp_cfg | input | 4 | Sample phase length in clock cycles (values below 2 act as 2) |
| cmp_ge | input | 1 | Comparator: held input is greater than or equal to the tap voltage |
| sh_sample | output | 1 | Sample/hold in tracking (sample) state |
| sh_hold | output | 1 | Sample/hold in hold state during the bit trials |
| tap_code | output | 12 | Code driven to the DAC tap selector |
| result | output | 12 | Latched conversion result |
| eoc_irq | output | 1 | One-cycle end-of-conversion interrupt pulse |
| busy | output | 1 | High from trigger acceptance until the result is latched |
| start_flag | output | 1 | Software start flag; set on acceptance, clears itself on completion |

## Verification
The assertions assume that `cmp_ge` is a settled function of the tap that was driven in the previous cycle. The bench meets this by computing `cmp_ge` combinationally from a stored input code and `tap_code`, which models an ideal comparator. The assertions also assume that start requests are single-cycle pulses and that `smp_cfg` stays constant while a conversion runs. The bench drives every pulse for exactly one cycle between falling edges, and it changes `smp_cfg` only while the block is idle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_SAMPLE = 2'd1,
        CS_TRIAL  = 2'd2
    } ctrl_state_e;

    typedef enum logic {
        TP_SETTLE = 1'b0,
        TP_DECIDE = 1'b1
    } trial_phase_e;

    typedef struct packed {
        logic accept;
        logic from_sw;
    } start_req_t;

    function automatic int unsigned floor_at(input int unsigned value, input int unsigned lo);
        return (value < lo) ? lo : value;
    endfunction

endpackage

// File: rtl/sar_trig_gate.sv
module sar_trig_gate (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    conv_en,
    input  logic                    idle,
    input  logic                    timer_mode,
    input  logic                    sw_start_wr,
    input  logic                    timer_trig,
    output sar_seq_pkg::start_req_t req
);
    import sar_seq_pkg::*;

    logic src_pulse;

    always_comb begin
        src_pulse   = timer_mode ? timer_trig : sw_start_wr;
        req.accept  = idle && conv_en && src_pulse;
        req.from_sw = req.accept && !timer_mode;
    end

    // R3
    timer_mode_no_swflag_chk: assert property (@(posedge clk) disable iff (rst)
        timer_mode |-> !req.from_sw);

endmodule

// File: rtl/sar_smp_timer.sv
module sar_smp_timer #(
    parameter int unsigned CFG_W   = 4,
    parameter int unsigned MIN_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [CFG_W-1:0] cfg,
    output logic             last
);
    import sar_seq_pkg::*;

    localparam logic [CFG_W-1:0] MIN_V = CFG_W'(MIN_CYC);

    logic [CFG_W-1:0] cnt;
    logic [CFG_W-1:0] load_val;

    always_comb begin
        load_val = CFG_W'(floor_at(int'(cfg), MIN_CYC));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = run && (cnt == CFG_W'(1));

    // R5
    smp_floor_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt >= MIN_V));

endmodule

// File: rtl/sar_trial_engine.sv
module sar_trial_engine #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic         cmp_ge,
    output logic [W-1:0] tap,
    output logic         done,
    output logic [W-1:0] final_code
);
    import sar_seq_pkg::*;

    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0]  sar;
    logic [W-1:0]  mask;
    logic          active;
    trial_phase_e  phase;
    logic [W-1:0]  decided;
    logic          deciding;

    always_comb begin
        deciding   = active && (phase == TP_DECIDE);
        decided    = cmp_ge ? sar : (sar & ~mask);
        done       = deciding && mask[0];
        final_code = decided;
        tap        = sar;
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            sar    <= '0;
            mask   <= '0;
            active <= 1'b0;
            phase  <= TP_SETTLE;
        end else if (start) begin
            sar    <= TOP_BIT;
            mask   <= TOP_BIT;
            active <= 1'b1;
            phase  <= TP_SETTLE;
        end else if (active && phase == TP_SETTLE) begin
            phase <= TP_DECIDE;
        end else if (deciding) begin
            phase <= TP_SETTLE;
            if (mask[0]) begin
                sar    <= '0;
                mask   <= '0;
                active <= 1'b0;
            end else begin
                sar  <= decided | (mask >> 1);
                mask <= mask >> 1;
            end
        end
    end

    // R7
    mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask));

    // R7
    bit_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (deciding && !abort && !cmp_ge && !mask[0]) |=> ((sar & $past(mask)) == '0));

    // R7
    bit_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (deciding && !abort && cmp_ge && !mask[0]) |=> ((sar & $past(mask)) != '0));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int unsigned SAR_W   = 12,
    parameter int unsigned SMP_W   = 4,
    parameter int unsigned SMP_MIN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_en,
    input  logic             trig_timer_mode,
    input  logic             sw_start_wr,
    input  logic             timer_trig,
    input  logic [SMP_W-1:0] smp_cfg,
    input  logic             cmp_ge,
    output logic             sh_sample,
    output logic             sh_hold,
    output logic [SAR_W-1:0] tap_code,
    output logic [SAR_W-1:0] result,
    output logic             eoc_irq,
    output logic             busy,
    output logic             start_flag
);
    import sar_seq_pkg::*;

    localparam logic [SAR_W-1:0] HALF_SCALE = {1'b1, {(SAR_W-1){1'b0}}};

    ctrl_state_e      state;
    ctrl_state_e      state_nx;
    start_req_t       req;
    logic             smp_last;
    logic             eng_start;
    logic             eng_abort;
    logic             eng_done;
    logic [SAR_W-1:0] eng_code;
    logic             finish;

    sar_trig_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .conv_en     (conv_en),
        .idle        (state == CS_IDLE),
        .timer_mode  (trig_timer_mode),
        .sw_start_wr (sw_start_wr),
        .timer_trig  (timer_trig),
        .req         (req)
    );

    sar_smp_timer #(
        .CFG_W   (SMP_W),
        .MIN_CYC (SMP_MIN)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (req.accept),
        .run  (state == CS_SAMPLE),
        .cfg  (smp_cfg),
        .last (smp_last)
    );

    sar_trial_engine #(
        .W (SAR_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (eng_start),
        .abort      (eng_abort),
        .cmp_ge     (cmp_ge),
        .tap        (tap_code),
        .done       (eng_done),
        .final_code (eng_code)
    );

    always_comb begin
        eng_abort = !conv_en && (state != CS_IDLE);
        eng_start = (state == CS_SAMPLE) && smp_last && conv_en;
        finish    = (state == CS_TRIAL) && eng_done && conv_en;
        state_nx  = state;
        unique case (state)
            CS_IDLE:   if (req.accept) state_nx = CS_SAMPLE;
            CS_SAMPLE: begin
                if (eng_abort)     state_nx = CS_IDLE;
                else if (smp_last) state_nx = CS_TRIAL;
            end
            CS_TRIAL: begin
                if (eng_abort || finish) state_nx = CS_IDLE;
            end
            default:   state_nx = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CS_IDLE;
            result     <= '0;
            eoc_irq    <= 1'b0;
            start_flag <= 1'b0;
        end else begin
            state   <= state_nx;
            eoc_irq <= finish;
            if (finish) begin
                result <= eng_code;
            end
            if (req.from_sw) begin
                start_flag <= 1'b1;
            end else if (finish || eng_abort) begin
                start_flag <= 1'b0;
            end
        end
    end

    assign busy      = (state != CS_IDLE);
    assign sh_sample = (state == CS_SAMPLE);
    assign sh_hold   = (state == CS_TRIAL);

    // R2
    start_into_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> sh_sample);

    // R4
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(conv_en));

    // R6
    first_tap_half_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sh_hold) |-> (tap_code == HALF_SCALE));

    // R6
    tap_only_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tap_code != '0) |-> sh_hold);

    // R8
    eoc_single_chk: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |=> !eoc_irq);

    // R8
    eoc_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |-> (!busy && $past(sh_hold)));

    // R8
    result_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !eoc_irq |-> $stable(result));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sh_hold) |-> !sh_sample);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |-> !start_flag);

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_en) |=> (!busy && !eoc_irq));

endmodule

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_en = 1'b0;
    logic        trig_timer_mode = 1'b0;
    logic        sw_start_wr = 1'b0;
    logic        timer_trig = 1'b0;
    logic [3:0]  smp_cfg = 4'd4;
    logic        cmp_ge;
    logic        sh_sample;
    logic        sh_hold;
    logic [11:0] tap_code;
    logic [11:0] result;
    logic        eoc_irq;
    logic        busy;
    logic        start_flag;
    logic [11:0] vin = 12'h000;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    assign cmp_ge = (vin >= tap_code);

    sar_conv_ctrl u_sar_conv_ctrl (
        .clk             (clk),
        .rst             (rst),
        .conv_en         (conv_en),
        .trig_timer_mode (trig_timer_mode),
        .sw_start_wr     (sw_start_wr),
        .timer_trig      (timer_trig),
        .smp_cfg         (smp_cfg),
        .cmp_ge          (cmp_ge),
        .sh_sample       (sh_sample),
        .sh_hold         (sh_hold),
        .tap_code        (tap_code),
        .result          (result),
        .eoc_irq         (eoc_irq),
        .busy            (busy),
        .start_flag      (start_flag)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_src(input bit use_timer, input bit v);
        if (use_timer) timer_trig = v;
        else           sw_start_wr = v;
    endtask

    // Full conversion; called at a falling edge with the block idle.
    task automatic do_conv(input bit use_timer, input logic [11:0] code,
                           input logic [3:0] cfg, input bit retrigger);
        int n;
        logic [11:0] tap2;
        n = (cfg < 4'd2) ? 2 : int'(cfg);
        tap2 = (code >= 12'h800) ? 12'hC00 : 12'h400;
        vin = code;
        smp_cfg = cfg;
        trig_timer_mode = use_timer;
        conv_en = 1'b1;
        pulse_src(use_timer, 1'b1);
        @(negedge clk);
        pulse_src(use_timer, 1'b0);
        check(busy == 1'b1, use_timer ? "R3" : "R2", "busy after start", busy, 1);
        check(start_flag == !use_timer, use_timer ? "R3" : "R2", "start_flag", start_flag, !use_timer);
        for (int k = 1; k <= n + 26; k++) begin
            if (k <= n) begin
                check(sh_sample && !sh_hold, "R5", "sample phase", {sh_sample, sh_hold}, 2'b10);
            end else if (k <= n + 24) begin
                check(sh_hold && !sh_sample, "R6", "hold phase", {sh_sample, sh_hold}, 2'b01);
            end
            if (k == n + 1 || k == n + 2) begin
                check(tap_code == 12'h800, "R6", "first tap", tap_code, 12'h800);
            end
            if (k == n + 3) begin
                check(tap_code == tap2, "R7", "second tap", tap_code, tap2);
            end
            if (k == n + 24) begin
                check(eoc_irq == 1'b0 && busy, "R8", "not yet complete", eoc_irq, 0);
            end
            if (k == n + 25) begin
                check(eoc_irq == 1'b1, "R8", "eoc pulse", eoc_irq, 1);
                check(result == code, "R8", "result", result, code);
                check(busy == 1'b0, "R8", "busy dropped", busy, 0);
                check(start_flag == 1'b0, "R10", "start_flag cleared", start_flag, 0);
                check(tap_code == 12'h000, "R6", "tap idle", tap_code, 0);
            end
            if (k == n + 26) begin
                check(eoc_irq == 1'b0, "R8", "eoc single cycle", eoc_irq, 0);
            end
            if (retrigger && k == 3) begin
                pulse_src(use_timer, 1'b1);
            end
            @(negedge clk);
            pulse_src(use_timer, 1'b0);
        end
        if (retrigger) begin
            check(busy == 1'b0, "R9", "no restart after retrigger", busy, 0);
        end
    endtask

    // A start pulse that must be ignored; observes the ports for a few cycles.
    task automatic ignored_start(input bit mode, input bit fire_timer, input bit en,
                                 input string req);
        logic [11:0] held;
        held = result;
        trig_timer_mode = mode;
        conv_en = en;
        pulse_src(fire_timer, 1'b1);
        @(negedge clk);
        pulse_src(fire_timer, 1'b0);
        for (int k = 0; k < 4; k++) begin
            check(!busy && !sh_sample && !start_flag, req, "ignored start",
                  {busy, sh_sample, start_flag}, 0);
            @(negedge clk);
        end
        check(result == held, req, "result untouched", result, held);
    endtask

    task automatic test_reset();
        check(result == 12'h000, "R1", "result", result, 0);
        check({busy, eoc_irq, sh_sample, sh_hold, start_flag} == 5'b0, "R1", "controls",
              {busy, eoc_irq, sh_sample, sh_hold, start_flag}, 0);
        check(tap_code == 12'h000, "R1", "tap", tap_code, 0);
    endtask

    task automatic test_abort();
        logic [11:0] held;
        held = result;
        vin = 12'h5A5;
        smp_cfg = 4'd3;
        trig_timer_mode = 1'b0;
        conv_en = 1'b1;
        sw_start_wr = 1'b1;
        @(negedge clk);
        sw_start_wr = 1'b0;
        repeat (7) @(negedge clk);
        check(sh_hold == 1'b1, "R11", "in trials before abort", sh_hold, 1);
        conv_en = 1'b0;
        @(negedge clk);
        check(!busy && !sh_hold && tap_code == 12'h000, "R11", "idle after abort",
              {busy, sh_hold}, 0);
        for (int k = 0; k < 30; k++) begin
            if (eoc_irq) check(1'b0, "R11", "eoc after abort", 1, 0);
            @(negedge clk);
        end
        check(result == held, "R11", "result kept", result, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        do_conv(1'b0, 12'hA5C, 4'd4, 1'b0);
        do_conv(1'b1, 12'h3F1, 4'd0, 1'b0);
        do_conv(1'b0, 12'hFFF, 4'd15, 1'b0);
        do_conv(1'b1, 12'h000, 4'd2, 1'b0);
        do_conv(1'b0, 12'h800, 4'd1, 1'b0);
        do_conv(1'b1, 12'h7FF, 4'd5, 1'b0);
        do_conv(1'b0, 12'h123, 4'd3, 1'b1);
        do_conv(1'b1, 12'hE0D, 4'd6, 1'b1);
        ignored_start(1'b0, 1'b1, 1'b1, "R2");
        ignored_start(1'b1, 1'b0, 1'b1, "R3");
        ignored_start(1'b0, 1'b0, 1'b0, "R4");
        ignored_start(1'b1, 1'b1, 1'b0, "R4");
        test_abort();
        do_conv(1'b0, 12'h9C3, 4'd2, 1'b0);
        summary();
    end

endmodule